// File: doc/BRIEF.md
# Flash Command Decoder with Status Register

This block is the command front end of a behavioural NOR-flash model. Bus writes arrive as single-cycle write strobes with an address and a data word. The block decodes them into word-program and whole-device-erase command sequences. It applies those operations to a small internal word array and tracks a status register. While an operation is in progress, a fixed busy interval stands in for the internal write state machine. Reads are combinational. In read-array mode a read returns the addressed word. After any program or erase command, a read returns the status word instead.

Protection has two sources. The first is a programming-voltage-valid flag. The second is a per-block lock vector, which only takes effect while the active-low write-protect pin is held low. Each failure cause leaves its own combination of error bits in the status register. The error bits stay set until a clear-status command arrives.

Top module: `flash_cmd_ui`

## Requirements
- R1: After reset the block is in read-array mode, every array word reads as all ones and the status word is 0x80.
- R2: A write of 0x40 or 0x10 (low byte) arms a program. The next accepted write replaces the word at its address with the old word AND the written data, so bits only go from 1 to 0. Asking for a 1 over a stored 0 raises no error. The block then returns the status word on reads.
- R3: Status bit 7 (ready) reads 0 for exactly BUSY_CYC cycles after the edge that starts an operation, and 1 otherwise. Every write taken while busy is ignored, including read-array, so an erase cannot be suspended.
- R4: A write of 0x20 followed by a write of 0xD0 sets every eligible array word to all ones and leaves the block in status mode.
- R5: If the write after 0x20 is anything other than 0xD0, status bits 4 and 5 are set, no operation starts and the array is unchanged.
- R6: With the voltage flag low, an erase confirm sets status bits 3 and 5, and a program data write sets status bits 3 and 4. Neither changes the array nor starts a busy interval.
- R7: While write-protect is low, erase skips every block whose lock bit is set. While write-protect is high, erase clears all blocks. The block index is the upper address bits above the in-block word offset.
- R8: A program to a locked block while write-protect is low sets status bits 1 and 4 and leaves the word unchanged. With write-protect high, the lock bit has no effect.
- R9: A write of 0x50 clears status bits 1, 3, 4 and 5. It does not change the read mode.
- R10: A write of 0xFF returns reads to array contents. Unrecognised opcodes in read-array or status mode change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle write strobe (stands for the strobe's rising edge) |
| addr | input | AW | Word address for writes and reads |
| wdata | input | DW | Write data; opcodes use the low byte |
| wp_n | input | 1 | Write-protect, active low; enables lock bits |
| vpp_ok | input | 1 | Programming voltage valid |
| lock_bits | input | NBLK | Per-block lock bits |
| rd_data | output | DW | Array word or zero-extended status word |

## Verification
The assertions assume that `wr_en` is a single-cycle pulse sampled with a stable address and data. They also assume that `lock_bits`, `wp_n` and `vpp_ok` do not change in the same cycle as the write they qualify. The stimulus follows these assumptions in two ways. Each write is a one-cycle pulse driven just after a clock edge. The protection inputs are changed only between command sequences, while no write is pending.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam logic [7:0] OP_READ_ARRAY = 8'hFF;
    localparam logic [7:0] OP_PGM_A      = 8'h40;
    localparam logic [7:0] OP_PGM_B      = 8'h10;
    localparam logic [7:0] OP_ERS_SETUP  = 8'h20;
    localparam logic [7:0] OP_CONFIRM    = 8'hD0;
    localparam logic [7:0] OP_CLR_STAT   = 8'h50;

    typedef enum logic [1:0] {
        MD_ARRAY   = 2'd0,
        MD_STATUS  = 2'd1,
        MD_PGM_ARG = 2'd2,
        MD_ERS_ARG = 2'd3
    } mode_e;

    typedef struct packed {
        logic ers;
        logic pgm;
        logic vpp;
        logic lock;
    } err_t;

    function automatic logic [7:0] status_byte(input logic ready, input err_t e);
        return {ready, 1'b0, e.ers, e.pgm, e.vpp, 1'b0, e.lock, 1'b0};
    endfunction

endpackage

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
    parameter int BUSY_CYC = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(BUSY_CYC + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CW'(BUSY_CYC);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);

    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);  // R3
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(BUSY_CYC));  // R3

endmodule

// File: rtl/flash_word_array.sv
module flash_word_array #(
    parameter int DW     = 16,
    parameter int AW     = 4,
    parameter int BLK_AW = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      pgm_en,
    input  logic [AW-1:0]             pgm_addr,
    input  logic [DW-1:0]             pgm_data,
    input  logic                      ers_en,
    input  logic [(1<<(AW-BLK_AW))-1:0] ers_mask,
    input  logic [AW-1:0]             rd_addr,
    output logic [DW-1:0]             rd_data
);
    localparam int NWORDS = 1 << AW;

    logic [DW-1:0] mem [NWORDS];

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        localparam int BLK = w >> BLK_AW;
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[w] <= '1;
            end else if (ers_en && ers_mask[BLK]) begin
                mem[w] <= '1;
            end else if (pgm_en && (pgm_addr == AW'(w))) begin
                mem[w] <= mem[w] & pgm_data;
            end
        end
    end

    assign rd_data = mem[rd_addr];

    logic          pgm_q;
    logic [AW-1:0] paddr_q;
    logic [DW-1:0] old_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pgm_q   <= 1'b0;
            paddr_q <= '0;
            old_q   <= '0;
        end else begin
            pgm_q   <= pgm_en && !ers_en;
            paddr_q <= pgm_addr;
            old_q   <= mem[pgm_addr];
        end
    end

    AST_PGM_NO_SET: assert property (@(posedge clk) disable iff (rst)
        pgm_q |-> ((mem[paddr_q] & ~old_q) == '0));  // R2

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int DW     = 16,
    parameter int AW     = 4,
    parameter int BLK_AW = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [AW-1:0]             addr,
    input  logic [DW-1:0]             wdata,
    input  logic                      wp_n,
    input  logic                      vpp_ok,
    input  logic [(1<<(AW-BLK_AW))-1:0] lock_bits,
    input  logic                      busy,
    output logic                      start,
    output logic                      pgm_en,
    output logic                      ers_en,
    output logic [(1<<(AW-BLK_AW))-1:0] ers_mask,
    output mode_e                     mode,
    output err_t                      err
);
    localparam int NBLK = 1 << (AW - BLK_AW);

    mode_e mode_q, mode_d;
    err_t  err_q, err_d;
    logic  accept;
    logic [7:0] op;
    logic [AW-BLK_AW-1:0] blk;
    logic  blk_locked;

    assign accept     = wr_en && !busy;
    assign op         = wdata[7:0];
    assign blk        = addr[AW-1:BLK_AW];
    assign blk_locked = lock_bits[blk] && !wp_n;

    for (genvar b = 0; b < NBLK; b++) begin : g_mask
        assign ers_mask[b] = wp_n || !lock_bits[b];
    end

    always_comb begin
        mode_d = mode_q;
        err_d  = err_q;
        pgm_en = 1'b0;
        ers_en = 1'b0;
        start  = 1'b0;
        if (accept) begin
            unique case (mode_q)
                MD_PGM_ARG: begin
                    mode_d = MD_STATUS;
                    if (!vpp_ok) begin
                        err_d.vpp = 1'b1;
                        err_d.pgm = 1'b1;
                    end else if (blk_locked) begin
                        err_d.lock = 1'b1;
                        err_d.pgm  = 1'b1;
                    end else begin
                        pgm_en = 1'b1;
                        start  = 1'b1;
                    end
                end
                MD_ERS_ARG: begin
                    mode_d = MD_STATUS;
                    if (op != OP_CONFIRM) begin
                        err_d.pgm = 1'b1;
                        err_d.ers = 1'b1;
                    end else if (!vpp_ok) begin
                        err_d.vpp = 1'b1;
                        err_d.ers = 1'b1;
                    end else begin
                        ers_en = 1'b1;
                        start  = 1'b1;
                    end
                end
                default: begin
                    case (op)
                        OP_READ_ARRAY:      mode_d = MD_ARRAY;
                        OP_PGM_A, OP_PGM_B: mode_d = MD_PGM_ARG;
                        OP_ERS_SETUP:       mode_d = MD_ERS_ARG;
                        OP_CLR_STAT:        err_d  = '0;
                        default:            mode_d = mode_q;
                    endcase
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MD_ARRAY;
            err_q  <= '0;
        end else begin
            mode_q <= mode_d;
            err_q  <= err_d;
        end
    end

    assign mode = mode_q;
    assign err  = err_q;

    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && busy) |=> ($stable(mode_q) && $stable(err_q)));  // R3
    AST_BAD_CONFIRM: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !busy && mode_q == MD_ERS_ARG && wdata[7:0] != OP_CONFIRM)
        |=> (err_q.pgm && err_q.ers && !busy));  // R5
    AST_ERS_LOWV: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !busy && mode_q == MD_ERS_ARG && wdata[7:0] == OP_CONFIRM && !vpp_ok)
        |=> (err_q.vpp && err_q.ers && !busy));  // R6
    AST_PGM_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !busy && mode_q == MD_PGM_ARG && vpp_ok && !wp_n && lock_bits[addr[AW-1:BLK_AW]])
        |=> (err_q.lock && err_q.pgm && !busy));  // R8
    AST_CLEAR_ERR: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !busy && (mode_q == MD_ARRAY || mode_q == MD_STATUS) && wdata[7:0] == OP_CLR_STAT)
        |=> (err_q == '0 && $stable(mode_q)));  // R9

endmodule

// File: rtl/flash_cmd_ui.sv
module flash_cmd_ui
    import flash_cmd_pkg::*;
#(
    parameter int DW       = 16,
    parameter int AW       = 4,
    parameter int BLK_AW   = 2,
    parameter int BUSY_CYC = 5,
    localparam int NBLK    = 1 << (AW - BLK_AW)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    input  logic            wp_n,
    input  logic            vpp_ok,
    input  logic [NBLK-1:0] lock_bits,
    output logic [DW-1:0]   rd_data
);
    logic            busy, start, pgm_en, ers_en;
    logic [NBLK-1:0] ers_mask;
    mode_e           mode;
    err_t            err;
    logic [DW-1:0]   arr_word;

    flash_cmd_fsm #(.DW(DW), .AW(AW), .BLK_AW(BLK_AW)) u_fsm (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .wp_n(wp_n), .vpp_ok(vpp_ok), .lock_bits(lock_bits), .busy(busy),
        .start(start), .pgm_en(pgm_en), .ers_en(ers_en), .ers_mask(ers_mask),
        .mode(mode), .err(err)
    );

    flash_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_timer (
        .clk(clk), .rst(rst), .start(start), .busy(busy)
    );

    flash_word_array #(.DW(DW), .AW(AW), .BLK_AW(BLK_AW)) u_array (
        .clk(clk), .rst(rst), .pgm_en(pgm_en), .pgm_addr(addr), .pgm_data(wdata),
        .ers_en(ers_en), .ers_mask(ers_mask), .rd_addr(addr), .rd_data(arr_word)
    );

    assign rd_data = (mode == MD_ARRAY) ? arr_word
                                        : DW'(status_byte(!busy, err));

endmodule

// File: tb/tb_flash_cmd_ui.sv
module tb_flash_cmd_ui;
    localparam int DW = 16, AW = 4, BLK_AW = 2, BUSY_CYC = 5;
    localparam int NW = 1 << AW, NBLK = 1 << (AW - BLK_AW);

    logic clk = 0, rst = 1, wr_en = 0, wp_n = 1, vpp_ok = 1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [NBLK-1:0] lock_bits = '0;
    logic [DW-1:0] rd_data;

    always #4 clk = ~clk;

    flash_cmd_ui #(.DW(DW), .AW(AW), .BLK_AW(BLK_AW), .BUSY_CYC(BUSY_CYC)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .wp_n(wp_n), .vpp_ok(vpp_ok), .lock_bits(lock_bits), .rd_data(rd_data)
    );

    int checks = 0, fails = 0;
    string cur_req = "R1";

    // reference model: 0 array reads, 1 status reads, 2 awaiting program data, 3 awaiting erase confirm
    int m_mode = 0, m_busy = 0;
    logic [DW-1:0] m_mem [NW];
    bit e_ers, e_pgm, e_vpp, e_lock;

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_busy = 0;
            e_ers = 0; e_pgm = 0; e_vpp = 0; e_lock = 0;
            for (int i = 0; i < NW; i++) m_mem[i] = '1;
        end else begin
            bit take;
            take = wr_en && (m_busy == 0);
            if (m_busy > 0) m_busy--;
            if (take) begin
                if (m_mode == 2) begin
                    m_mode = 1;
                    if (!vpp_ok) begin e_vpp = 1; e_pgm = 1; end
                    else if (!wp_n && lock_bits[int'(addr) / (1 << BLK_AW)]) begin e_lock = 1; e_pgm = 1; end
                    else begin m_mem[addr] = m_mem[addr] & wdata; m_busy = BUSY_CYC; end
                end else if (m_mode == 3) begin
                    m_mode = 1;
                    if (wdata[7:0] != 8'hD0) begin e_pgm = 1; e_ers = 1; end
                    else if (!vpp_ok) begin e_vpp = 1; e_ers = 1; end
                    else begin
                        for (int i = 0; i < NW; i++)
                            if (wp_n || !lock_bits[i / (1 << BLK_AW)]) m_mem[i] = '1;
                        m_busy = BUSY_CYC;
                    end
                end else begin
                    case (wdata[7:0])
                        8'hFF: m_mode = 0;
                        8'h40, 8'h10: m_mode = 2;
                        8'h20: m_mode = 3;
                        8'h50: begin e_ers = 0; e_pgm = 0; e_vpp = 0; e_lock = 0; end
                        default: ;
                    endcase
                end
            end
        end
    end

    function automatic logic [DW-1:0] model_read();
        if (m_mode == 0) return m_mem[addr];
        return DW'({(m_busy == 0), 1'b0, e_ers, e_pgm, e_vpp, 1'b0, e_lock, 1'b0});
    endfunction

    task automatic chk(string req, logic [DW-1:0] got, logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h (t=%0t)", req, got, exp, $time);
        end
    endtask

    always @(negedge clk) if (!rst) chk(cur_req, rd_data, model_read());

    task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
        @(posedge clk); #1 wr_en = 1; addr = a; wdata = d;
        @(posedge clk); #1 wr_en = 0;
    endtask

    task automatic rd_at(logic [AW-1:0] a);
        @(posedge clk); #1 addr = a;
    endtask

    task automatic settle();
        repeat (BUSY_CYC + 2) @(posedge clk);
    endtask

    task automatic sweep();
        for (int i = 0; i < NW; i++) rd_at(AW'(i));
    endtask

    bit done = 0;
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: got hang expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        cur_req = "R1";
        @(negedge clk); chk("R1", rd_data, 16'hFFFF);
        sweep();
        wr(0, 16'h0050); wr(0, 16'h0070); @(negedge clk);
        chk("R1", rd_data, 16'hFFFF);  // clear/unknown in array mode: still array reads

        cur_req = "R2";
        wr(0, 16'h0040); wr(5, 16'h1234);
        cur_req = "R3";
        @(negedge clk); chk("R3", rd_data, 16'h0000);
        wr(0, 16'h00FF);  // ignored while busy
        settle(); @(negedge clk); chk("R3", rd_data, 16'h0080);
        cur_req = "R2";
        wr(0, 16'h00FF); rd_at(5); @(negedge clk); chk("R2", rd_data, 16'h1234);
        wr(5, 16'h0010); wr(5, 16'hFF0F); settle(); @(negedge clk);
        chk("R2", rd_data, 16'h0080);
        wr(0, 16'h00FF); rd_at(5); @(negedge clk); chk("R2", rd_data, 16'h1204);
        wr(0, 16'h0040); wr(9, 16'h00AA); settle();
        wr(0, 16'h0040); wr(14, 16'h5500); settle();
        wr(0, 16'h0040); wr(2, 16'h0F0F); settle();

        cur_req = "R5";
        wr(0, 16'h0020); wr(0, 16'h0040); @(negedge clk); chk("R5", rd_data, 16'h00B0);
        cur_req = "R9";
        wr(0, 16'h0050); @(negedge clk); chk("R9", rd_data, 16'h0080);
        wr(0, 16'h00FF); sweep();

        cur_req = "R6";
        vpp_ok = 0;
        wr(0, 16'h0020); wr(0, 16'h00D0); @(negedge clk); chk("R6", rd_data, 16'h00A8);
        wr(0, 16'h0050);
        wr(0, 16'h0040); wr(9, 16'h0000); @(negedge clk); chk("R6", rd_data, 16'h0098);
        vpp_ok = 1;
        wr(0, 16'h0050); wr(0, 16'h00FF); sweep();

        cur_req = "R8";
        lock_bits = 4'b0101; wp_n = 0;
        wr(0, 16'h0040); wr(1, 16'h0000); @(negedge clk); chk("R8", rd_data, 16'h0092);
        wr(0, 16'h0050); wr(0, 16'h00FF); rd_at(1); @(negedge clk); chk("R8", rd_data, 16'hFFFF);
        wp_n = 1;
        wr(0, 16'h0040); wr(1, 16'h00F0); settle();
        wr(0, 16'h00FF); rd_at(1); @(negedge clk); chk("R8", rd_data, 16'h00F0);

        cur_req = "R7";
        wp_n = 0;
        wr(0, 16'h0040); wr(6, 16'h0001); settle();
        wr(0, 16'h0020); wr(3, 16'h00D0);
        cur_req = "R3";
        wr(0, 16'h00FF); wr(0, 16'h0050);  // erase cannot be suspended
        settle();
        cur_req = "R7";
        wr(0, 16'h00FF); sweep();
        rd_at(1); @(negedge clk); chk("R7", rd_data, 16'h00F0);
        rd_at(6); @(negedge clk); chk("R7", rd_data, 16'hFFFF);

        cur_req = "R4";
        wp_n = 1;
        wr(0, 16'h0020); wr(0, 16'h00D0); settle();
        wr(0, 16'h00FF); sweep();
        rd_at(1); @(negedge clk); chk("R4", rd_data, 16'hFFFF);

        cur_req = "R10";
        wr(0, 16'h0040); wr(4, 16'h0000); settle();
        wr(0, 16'h0077); @(negedge clk); chk("R10", rd_data, 16'h0080);
        wr(0, 16'h00FF); rd_at(4); @(negedge clk); chk("R10", rd_data, 16'h0000);
        wr(0, 16'h0033); sweep();

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule